// File: doc/BRIEF.md
# Immediate-Add Execution Unit

This unit carries out a single DSP operation. It adds a 16-bit signed immediate to one of eight 40-bit data registers. The instruction arrives as two 16-bit words. The unit checks the fixed opcode bits in both words, assembles the immediate from the pieces split across them, and picks the destination from a 3-bit field. It writes the wrapped 40-bit sum back to that register on the clock edge at which the instruction is issued.

Each data register has a limit bit, and the operation clears the limit bit of its destination. A small status register holds a carry bit and an overflow flag. The operation never changes the carry bit. The overflow flag is sticky: a signed 40-bit overflow sets it, and it stays set until reset or an explicit status write clears it.

A load port preloads registers and their limit bits, and a read port observes them. An instruction whose fixed bits do not match is rejected. The unit then raises a one-cycle illegal flag and changes no state.

Top module: `iadd_exec_unit`

## Requirements
- R1: The immediate is `{w0[7:5], w1[12:0]}` (word 0 bits 7..5 give immediate bits 15..13). It is sign-extended to 40 bits and added to the destination, and the result is kept modulo 2^40.
- R2: The result is never saturated. A sum that overflows is written as the wrapped 40-bit value.
- R3: An executed instruction leaves `carry_o` unchanged.
- R4: The overflow flag `ovf_o` is set when the operands have the same sign and the 40-bit result has the other sign.
- R5: `ovf_o` is sticky. An executed instruction never clears it, and only reset or a status write (`stat_wr_en`) changes it to 0.
- R6: An executed instruction clears the limit bit of its destination register and leaves the limit bits of all other registers unchanged.
- R7: The destination field `w0[2:0]` selects register index 0..7 directly. Registers other than the destination keep their contents.
- R8: An instruction is legal only when `w0[15:8]==8'h3A`, `w0[4:3]==2'b10` and `w1[15:13]==3'b100`. An illegal issue sets `illegal_o` for the next cycle and changes no register, limit bit or flag.
- R9: The instruction completes in one cycle. The new value is readable on `rd_data` right after the clock edge at which `exec_valid` is sampled high.
- R10: Reset, which is synchronous and active high, clears all registers, limit bits, `carry_o`, `ovf_o` and `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Issue the instruction on `instr_w0`/`instr_w1` |
| instr_w0 | input | 16 | First instruction word |
| instr_w1 | input | 16 | Second instruction word |
| load_en | input | 1 | Preload a register |
| load_sel | input | 3 | Register index to preload |
| load_data | input | 40 | Value to preload |
| load_limit | input | 1 | Limit bit to preload |
| rd_sel | input | 3 | Register index to observe |
| rd_data | output | 40 | Contents of the observed register |
| rd_limit | output | 1 | Limit bit of the observed register |
| stat_wr_en | input | 1 | Write the status register |
| stat_wr_carry | input | 1 | Carry value to write |
| stat_wr_ovf | input | 1 | Overflow value to write |
| carry_o | output | 1 | Carry bit |
| ovf_o | output | 1 | Sticky overflow flag |
| illegal_o | output | 1 | Previous issue was rejected |

## Verification
The bench targets the boundaries of the overflow rule. It runs a positive register plus a positive immediate past the top of the range, and the most negative register plus -1. A design that saturated would write the clamped value there, and a design that tested overflow at the wrong bit would miss one case. It also runs a negative sum that does not overflow, where a design that wrongly raised the flag would be caught. The bench issues a non-overflowing instruction after an overflow to catch a flag that is not sticky, and it checks the carry and the untouched registers to catch writes that spill over. Finally, it corrupts one opcode bit in each word. A design that decoded loosely would write the register or fail to raise `illegal_o`.

// File: rtl/iadd_pkg.sv
package iadd_pkg;

    localparam int DATA_W   = 40;
    localparam int IMM_W    = 16;
    localparam int WORD_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int SEL_W    = $clog2(NUM_REGS);

    // Fixed opcode fields (positions are decoded, so they are kept)
    localparam logic [7:0] OPC_W0_HI  = 8'h3A;
    localparam logic [1:0] OPC_W0_MID = 2'b10;
    localparam logic [2:0] OPC_W1_HI  = 3'b100;

    typedef struct packed {
        logic             legal;
        logic [SEL_W-1:0] dst;
        logic [IMM_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              ovf;
    } alu_res_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/iadd_decode.sv
module iadd_decode
    import iadd_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    output dec_t              dec
);
    always_comb begin
        dec.legal = (w0[15:8] == OPC_W0_HI) &&
                    (w0[4:3]  == OPC_W0_MID) &&
                    (w1[15:13] == OPC_W1_HI);
        dec.dst   = w0[2:0];
        dec.imm   = {w0[7:5], w1[12:0]};
    end
endmodule

// File: rtl/iadd_alu.sv
module iadd_alu
    import iadd_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [IMM_W-1:0]  imm,
    output alu_res_t          res
);
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] raw;
    logic              a_msb, b_msb;

    always_comb begin
        addend  = sext_imm(imm);
        raw     = operand + addend;
        a_msb   = operand[DATA_W-1];
        b_msb   = addend[DATA_W-1];
        res.sum = raw;
        res.ovf = (a_msb == b_msb) && (raw[DATA_W-1] != a_msb);
    end
endmodule

// File: rtl/iadd_regfile.sv
module iadd_regfile #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 40,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_we,
    input  logic [SEL_W-1:0]  exec_sel,
    input  logic [DATA_W-1:0] exec_data,
    input  logic              load_we,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_limit,
    output logic [DATA_W-1:0] src_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_limit
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_REGS-1:0]             lim_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
                lim_q[i]  <= 1'b0;
            end else if (exec_we && exec_sel == SEL_W'(i)) begin
                regs_q[i] <= exec_data;
                lim_q[i]  <= 1'b0;
            end else if (load_we && load_sel == SEL_W'(i)) begin
                regs_q[i] <= load_data;
                lim_q[i]  <= load_limit;
            end
        end
    end

    assign src_data = regs_q[exec_sel];
    assign rd_data  = regs_q[rd_sel];
    assign rd_limit = lim_q[rd_sel];

    // R6: an executed write leaves the destination limit bit clear
    assert_limit_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        exec_we |=> !lim_q[$past(exec_sel)]);

    // R7/R8: with no write of either kind, no register or limit bit moves
    assert_regs_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!exec_we && !load_we) |=> ($stable(regs_q) && $stable(lim_q)));
endmodule

// File: rtl/iadd_status.sv
module iadd_status (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_carry,
    input  logic wr_ovf,
    input  logic set_ovf,
    output logic carry,
    output logic ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            carry <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (wr_en) carry <= wr_carry;
            ovf <= (wr_en ? wr_ovf : ovf) | set_ovf;
        end
    end

    // R3: only a status write may move the carry bit
    assert_carry_kept_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(carry));

    // R5: without a status write a set flag stays set
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !wr_en) |=> ovf);
endmodule

// File: rtl/iadd_exec_unit.sv
module iadd_exec_unit
    import iadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_valid,
    input  logic [15:0]       instr_w0,
    input  logic [15:0]       instr_w1,
    input  logic              load_en,
    input  logic [2:0]        load_sel,
    input  logic [39:0]       load_data,
    input  logic              load_limit,
    input  logic [2:0]        rd_sel,
    output logic [39:0]       rd_data,
    output logic              rd_limit,
    input  logic              stat_wr_en,
    input  logic              stat_wr_carry,
    input  logic              stat_wr_ovf,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              illegal_o
);
    dec_t              dec;
    alu_res_t          res;
    logic [DATA_W-1:0] src;
    logic              fire;
    logic              illegal_q;

    iadd_decode u_dec (.w0(instr_w0), .w1(instr_w1), .dec(dec));

    assign fire = exec_valid && dec.legal;

    iadd_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst(rst),
        .exec_we(fire), .exec_sel(dec.dst), .exec_data(res.sum),
        .load_we(load_en), .load_sel(load_sel), .load_data(load_data),
        .load_limit(load_limit),
        .src_data(src),
        .rd_sel(rd_sel), .rd_data(rd_data), .rd_limit(rd_limit)
    );

    iadd_alu u_alu (.operand(src), .imm(dec.imm), .res(res));

    iadd_status u_st (
        .clk(clk), .rst(rst),
        .wr_en(stat_wr_en), .wr_carry(stat_wr_carry), .wr_ovf(stat_wr_ovf),
        .set_ovf(fire && res.ovf),
        .carry(carry_o), .ovf(ovf_o)
    );

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= exec_valid && !dec.legal;
    end
    assign illegal_o = illegal_q;

    // R8: a rejection is only ever reported for an issued instruction
    assert_illegal_on_issue_R8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(exec_valid));
endmodule

// File: tb/iadd_exec_unit_tb.sv
module iadd_exec_unit_tb;
    logic        clk = 0;
    logic        rst;
    logic        exec_valid;
    logic [15:0] instr_w0, instr_w1;
    logic        load_en, load_limit;
    logic [2:0]  load_sel, rd_sel;
    logic [39:0] load_data, rd_data;
    logic        rd_limit;
    logic        stat_wr_en, stat_wr_carry, stat_wr_ovf;
    logic        carry_o, ovf_o, illegal_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    iadd_exec_unit u_dut (.*);

    function automatic logic [15:0] enc0(input logic [2:0] r, input logic [15:0] imm);
        return {8'h3A, imm[15:13], 2'b10, r};
    endfunction
    function automatic logic [15:0] enc1(input logic [15:0] imm);
        return {3'b100, imm[12:0]};
    endfunction

    // Independent reference: signed integer arithmetic
    function automatic logic [39:0] ref_sum(input logic [39:0] d, input logic [15:0] imm);
        longint s;
        s = longint'(signed'(d)) + longint'(signed'(imm));
        return s[39:0];
    endfunction
    function automatic bit ref_ovf(input logic [39:0] d, input logic [15:0] imm);
        longint s;
        s = longint'(signed'(d)) + longint'(signed'(imm));
        return (s > 64'sh7F_FFFF_FFFF) || (s < -64'sh80_0000_0000);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] r, input logic [39:0] d, input logic l);
        @(negedge clk);
        load_en = 1; load_sel = r; load_data = d; load_limit = l;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic issue(input logic [15:0] w0, input logic [15:0] w1);
        @(negedge clk);
        exec_valid = 1; instr_w0 = w0; instr_w1 = w1;
        @(negedge clk);
        exec_valid = 0;
    endtask

    task automatic set_status(input logic c, input logic o);
        @(negedge clk);
        stat_wr_en = 1; stat_wr_carry = c; stat_wr_ovf = o;
        @(negedge clk);
        stat_wr_en = 0;
    endtask

    task automatic check_reg(input string req, input logic [2:0] r,
                             input logic [39:0] d, input logic l);
        rd_sel = r; #1;
        check(req, rd_data, d);
        check(req, rd_limit, l);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) check_reg("R10 reg", 3'(i), 40'h0, 1'b0);
        check("R10 carry", carry_o, 0);
        check("R10 ovf", ovf_o, 0);
        check("R10 illegal", illegal_o, 0);
    endtask

    task automatic t_example;
        load(3'd2, 40'hFF_FFFF_CA3E, 1'b1);
        issue(enc0(3'd2, 16'hA002), enc1(16'hA002));
        check_reg("R1/R6/R9 example", 3'd2, 40'hFF_FFFF_6A40, 1'b0);
        check("R4 no ovf", ovf_o, 0);
    endtask

    task automatic t_mapping;
        for (int i = 0; i < 8; i++) load(3'(i), 40'h11_0000_0000 * (i + 1), 1'b1);
        issue(enc0(3'd7, 16'h0123), enc1(16'h0123));
        check_reg("R7 D7 written", 3'd7, ref_sum(40'h11_0000_0000 * 8, 16'h0123), 1'b0);
        issue(enc0(3'd0, 16'hFFF0), enc1(16'hFFF0));
        check_reg("R7 D0 written", 3'd0, ref_sum(40'h11_0000_0000, 16'hFFF0), 1'b0);
        for (int i = 1; i < 7; i++)
            check_reg("R7/R6 others untouched", 3'(i), 40'h11_0000_0000 * (i + 1), 1'b1);
    endtask

    task automatic t_carry;
        set_status(1'b1, 1'b0);
        issue(enc0(3'd3, 16'h7FFF), enc1(16'h7FFF));
        check("R3 carry kept at 1", carry_o, 1);
        set_status(1'b0, 1'b0);
        issue(enc0(3'd3, 16'h8000), enc1(16'h8000));
        check("R3 carry kept at 0", carry_o, 0);
    endtask

    task automatic t_overflow;
        logic [39:0] d;
        d = 40'h7F_FFFF_FFF0;
        load(3'd5, d, 1'b1);
        issue(enc0(3'd5, 16'h0020), enc1(16'h0020));
        check_reg("R2 positive wrap", 3'd5, ref_sum(d, 16'h0020), 1'b0);
        check("R4 positive ovf", ovf_o, ref_ovf(d, 16'h0020));
        issue(enc0(3'd5, 16'h0001), enc1(16'h0001));
        check("R5 sticky after clean add", ovf_o, 1);
        set_status(1'b0, 1'b0);
        check("R5 cleared by status write", ovf_o, 0);
        d = 40'h80_0000_0000;
        load(3'd6, d, 1'b0);
        issue(enc0(3'd6, 16'hFFFF), enc1(16'hFFFF));
        check_reg("R2 negative wrap", 3'd6, ref_sum(d, 16'hFFFF), 1'b0);
        check("R4 negative ovf", ovf_o, ref_ovf(d, 16'hFFFF));
        set_status(1'b0, 1'b0);
        d = 40'h80_0000_0010;
        load(3'd6, d, 1'b0);
        issue(enc0(3'd6, 16'hFFF0), enc1(16'hFFF0));
        check_reg("R1 most negative reached", 3'd6, 40'h80_0000_0000, 1'b0);
        check("R4 no ovf at edge", ovf_o, 0);
    endtask

    task automatic t_illegal;
        load(3'd4, 40'h12_3456_789A, 1'b1);
        issue(enc0(3'd4, 16'h0005) ^ 16'h0100, enc1(16'h0005));
        check("R8 illegal w0", illegal_o, 1);
        check_reg("R8 w0 no write", 3'd4, 40'h12_3456_789A, 1'b1);
        issue(enc0(3'd4, 16'h0005), enc1(16'h0005) ^ 16'h4000);
        check("R8 illegal w1", illegal_o, 1);
        issue(enc0(3'd4, 16'h0005) ^ 16'h0010, enc1(16'h0005));
        check("R8 illegal mid bits", illegal_o, 1);
        check_reg("R8 no write", 3'd4, 40'h12_3456_789A, 1'b1);
        check("R8 ovf untouched", ovf_o, 0);
        issue(enc0(3'd4, 16'h0005), enc1(16'h0005));
        check("R8 legal not flagged", illegal_o, 0);
        check_reg("R8 legal executes", 3'd4, 40'h12_3456_789F, 1'b0);
    endtask

    initial begin
        rst = 1; exec_valid = 0; instr_w0 = 0; instr_w1 = 0;
        load_en = 0; load_sel = 0; load_data = 0; load_limit = 0;
        rd_sel = 0; stat_wr_en = 0; stat_wr_carry = 0; stat_wr_ovf = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_example;
        t_mapping;
        t_carry;
        t_overflow;
        t_illegal;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule